// File: doc/BRIEF.md
# Register-List Stack Push Sequencer

This block runs a function-prologue save. One request brings a 12-bit register-selection mask, a 5-bit frame-size immediate and the current stack pointer. The block then writes every selected register to a stack that grows downward, one 32-bit word per cycle. After the last write it spends one more cycle taking extra frame space: it lowers the stack pointer by the zero-extended immediate. It then reports completion together with the new stack pointer.

Each mask bit stands for one register. Bit `i` selects register number `REG_BASE + i`, which by default gives registers 20 to 31. Registers are saved from the highest set bit down to the lowest. The block reads each value through a combinational register-file read port and sends it out on a word store port in the same cycle.

The controller is a three-state machine:
- `S_IDLE`: waits for a request.
- `S_PUSH`: issues one store per cycle.
- `S_ADJ`: makes the final frame adjustment and raises done.

Its transitions are:
- **launch**: `S_IDLE`→`S_PUSH` on a start with a non-empty mask.
- **launch-empty**: `S_IDLE`→`S_ADJ` on a start with an empty mask.
- **push-more**: `S_PUSH`→`S_PUSH` while set bits remain.
- **push-last**: `S_PUSH`→`S_ADJ` after the last set bit is stored.
- **finish**: `S_ADJ`→`S_IDLE`, always.

Top module: `frame_push_seq`

## Requirements
- R1: After reset `busy_o`, `done_o` and `st_valid_o` are 0, and `sp_o` is 0.
- R2: In `S_IDLE`, a high `start_i` at a rising edge captures `mask_i`, `imm_i` and `sp_i`. `busy_o` is 1 from the next cycle until the block returns to `S_IDLE`.
- R3: Every store's address equals the current stack pointer minus 4. The stack pointer drops by 4 after each store, so consecutive stores are 4 apart and the first is at the captured `sp_i` minus 4.
- R4: Mask bit `i` selects register `REG_BASE + i` (default 20). Stores run from the highest set bit to the lowest. In a store cycle `rd_addr_o` names the register, and `st_data_o` carries `rd_data_i` from that same cycle.
- R5: Each set mask bit produces exactly one store, and clear bits produce none.
- R6: After the pushes, one cycle has `done_o` = 1. In that cycle `sp_o` equals the pushed stack pointer minus the zero-extended `imm_i`, and `sp_o` keeps that value after `done_o` falls.
- R7: With n set bits, `done_o` appears in the (n+1)-th cycle after the start edge.
- R8: An all-zero mask issues no store, and `done_o` appears in the first cycle after the start, with `sp_o` = `sp_i` − `imm_i`.
- R9: `start_i` is ignored in `S_PUSH` and `S_ADJ`. The running operation's stores and final stack pointer do not change, and no new operation begins after `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a push operation |
| mask_i | input | 12 | Register-selection mask |
| imm_i | input | 5 | Extra frame size in bytes, zero-extended |
| sp_i | input | 32 | Stack pointer at start |
| sp_o | output | 32 | Current stack pointer; final value valid with done |
| rd_addr_o | output | 5 | Register-file read index |
| rd_data_i | input | 32 | Register-file read data, same cycle |
| st_valid_o | output | 1 | Word store request |
| st_addr_o | output | 32 | Store byte address |
| st_data_o | output | 32 | Store data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The empty mask exercises the launch-empty path and separates the adjustment step from the push path. The all-ones mask exercises the longest run and the exit on the lowest bit. Masks with only the top bit or only the bottom bit set show whether bit-to-register mapping and the push-last exit are correct at both ends. Random and patterned masks expose ordering, skipped or repeated stores, and off-by-one cycle counts. Some runs keep `start_i` high with different operands for the whole operation, which shows whether a busy sequencer ignores the request. A stack pointer near zero checks that address arithmetic wraps.

// File: rtl/frame_push_pkg.sv
package frame_push_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_PUSH = 2'd1,
        S_ADJ  = 2'd2
    } push_state_e;

endpackage

// File: rtl/push_pick.sv
module push_pick #(
    parameter int W     = 12,
    localparam int IDXW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]    vec,
    output logic [W-1:0]    onehot,
    output logic [IDXW-1:0] idx
);

    // onehot marks the highest set bit of vec
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_sel
            if (g == W - 1) begin : g_top
                assign onehot[g] = vec[g];
            end else begin : g_low
                assign onehot[g] = vec[g] & ~(|vec[W-1:g+1]);
            end
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (onehot[i]) idx = IDXW'(i);
        end
    end

endmodule

// File: rtl/push_sp.sv
module push_sp #(
    parameter int AW    = 32,
    parameter int IMM_W = 5,
    parameter int WORD  = 4
) (
    input  logic [AW-1:0]    sp,
    input  logic [IMM_W-1:0] imm,
    output logic [AW-1:0]    sp_word,
    output logic [AW-1:0]    sp_frame
);

    assign sp_word  = sp - AW'(WORD);
    assign sp_frame = sp - {{(AW-IMM_W){1'b0}}, imm};

endmodule

// File: rtl/frame_push_seq.sv
module frame_push_seq
    import frame_push_pkg::*;
#(
    parameter int LIST_W   = 12,
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int IMM_W    = 5,
    parameter int RIDX_W   = 5,
    parameter int REG_BASE = 20,
    parameter int WORD     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LIST_W-1:0] mask_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [ADDR_W-1:0] sp_i,
    output logic [ADDR_W-1:0] sp_o,
    output logic [RIDX_W-1:0] rd_addr_o,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              st_valid_o,
    output logic [ADDR_W-1:0] st_addr_o,
    output logic [DATA_W-1:0] st_data_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int SEL_W = (LIST_W > 1) ? $clog2(LIST_W) : 1;

    push_state_e       state_q, state_d;
    logic [LIST_W-1:0] mask_q;
    logic [IMM_W-1:0]  imm_q;
    logic [ADDR_W-1:0] sp_q;

    logic [LIST_W-1:0] pick_onehot;
    logic [SEL_W-1:0]  pick_idx;
    logic [LIST_W-1:0] mask_rest;
    logic [ADDR_W-1:0] sp_word, sp_frame;

    push_pick #(.W(LIST_W)) u_pick (
        .vec    (mask_q),
        .onehot (pick_onehot),
        .idx    (pick_idx)
    );

    push_sp #(.AW(ADDR_W), .IMM_W(IMM_W), .WORD(WORD)) u_sp (
        .sp       (sp_q),
        .imm      (imm_q),
        .sp_word  (sp_word),
        .sp_frame (sp_frame)
    );

    assign mask_rest = mask_q & ~pick_onehot;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start_i) state_d = (mask_i != '0) ? S_PUSH : S_ADJ;
            S_PUSH: if (mask_rest == '0) state_d = S_ADJ;
            S_ADJ:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // operand and stack-pointer registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            imm_q  <= '0;
            sp_q   <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start_i) begin
                    mask_q <= mask_i;
                    imm_q  <= imm_i;
                    sp_q   <= sp_i;
                end
                S_PUSH: begin
                    mask_q <= mask_rest;
                    sp_q   <= sp_word;
                end
                S_ADJ:  sp_q <= sp_frame;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        st_valid_o = 1'b0;
        done_o     = 1'b0;
        busy_o     = 1'b1;
        sp_o       = sp_q;
        unique case (state_q)
            S_IDLE: busy_o = 1'b0;
            S_PUSH: st_valid_o = 1'b1;
            S_ADJ: begin
                done_o = 1'b1;
                sp_o   = sp_frame;
            end
            default: busy_o = 1'b0;
        endcase
        rd_addr_o = RIDX_W'(REG_BASE) + RIDX_W'(pick_idx);
        st_addr_o = sp_word;
        st_data_o = rd_data_i;
    end

    AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid_o |=> (sp_q == $past(st_addr_o)));                          // R3
    AST_DESCENDING_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid_o && $past(st_valid_o)) |-> (rd_addr_o < $past(rd_addr_o))); // R4
    AST_SINGLE_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid_o |-> ($countones(pick_onehot) == 1));                       // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                                  // R6
    AST_EMPTY_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && mask_i == '0) |=> done_o);                     // R8
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);                                                  // R9

endmodule

// File: tb/tb_frame_push_seq.sv
`timescale 1ns/1ps
module tb_frame_push_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] mask = '0;
    logic [4:0]  imm = '0;
    logic [31:0] sp_in = '0;
    logic [31:0] sp_out, st_addr, st_data, rd_data;
    logic [4:0]  rd_addr;
    logic        st_valid, busy, done;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [31:0] q_addr[$];
    logic [31:0] q_data[$];
    logic [4:0]  q_reg[$];
    logic [31:0] exp_sp;
    int          exp_n;
    int          start_cyc;
    bit          op_live = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // register-file model
    assign rd_data = {16'hD00D, 11'd0, rd_addr};

    frame_push_seq dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mask_i(mask), .imm_i(imm),
        .sp_i(sp_in), .sp_o(sp_out), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
        .st_valid_o(st_valid), .st_addr_o(st_addr), .st_data_o(st_data),
        .busy_o(busy), .done_o(done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // monitor: pops the scoreboard as stores and completions appear
    always @(negedge clk) begin
        if (rst_n && st_valid) begin
            if (q_addr.size() == 0) begin
                chk(1'b0, "R5 unexpected store", st_addr, 32'h0);
            end else begin
                logic [31:0] ea, ed;
                logic [4:0]  er;
                ea = q_addr.pop_front();
                ed = q_data.pop_front();
                er = q_reg.pop_front();
                chk(st_addr == ea, "R3 store address", st_addr, ea);
                chk(rd_addr == er, "R4 register order", {27'd0, rd_addr}, {27'd0, er});
                chk(st_data == ed, "R4 store data", st_data, ed);
            end
        end
        if (rst_n && done) begin
            chk(op_live, "R9 done without operation", 32'd0, 32'd1);
            chk(sp_out == exp_sp, "R6 final stack pointer", sp_out, exp_sp);
            chk(q_addr.size() == 0, "R5 missing stores", q_addr.size(), 32'd0);
            chk(cyc - start_cyc == exp_n + 1, "R7 cycle count",
                cyc - start_cyc, exp_n + 1);
        end
    end

    // driver: builds the expected stores, then launches the operation
    task automatic run_op(input logic [11:0] m, input logic [4:0] im,
                          input logic [31:0] s, input bit pester);
        logic [31:0] p = s;
        int n = 0;
        int guard = 0;
        for (int i = 11; i >= 0; i--) begin
            if (m[i]) begin
                p = p - 32'd4;
                q_addr.push_back(p);
                q_reg.push_back(5'(20 + i));
                q_data.push_back({16'hD00D, 11'd0, 5'(20 + i)});
                n++;
            end
        end
        exp_sp = p - {27'd0, im};
        exp_n  = n;
        @(negedge clk);
        start = 1'b1; mask = m; imm = im; sp_in = s;
        start_cyc = cyc;
        op_live = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R2 busy after start", {31'd0, busy}, 32'd1);
        if (pester) begin
            mask = ~m; imm = ~im; sp_in = s ^ 32'h0000_F000;
        end else begin
            start = 1'b0;
        end
        while (!done && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 100) chk(1'b0, "R7 watchdog on done", 32'd0, 32'd1);
        start = 1'b0;
        @(negedge clk);
        op_live = 1'b0;
        chk(busy == 1'b0, "R9 no restart after done", {31'd0, busy}, 32'd0);
        chk(sp_out == exp_sp, "R6 stack pointer holds", sp_out, exp_sp);
        if (m == 12'h000)
            chk(n == 0, "R8 empty mask stores", n, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && st_valid == 1'b0, "R1 reset controls",
            {29'd0, busy, done, st_valid}, 32'd0);
        chk(sp_out == 32'd0, "R1 reset stack pointer", sp_out, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op(12'h000, 5'd7,  32'h0000_1000, 1'b0);  // R8
        run_op(12'hFFF, 5'd31, 32'h0000_2000, 1'b0);  // R5 all ones
        run_op(12'h001, 5'd0,  32'h0000_3000, 1'b0);  // R4 lowest bit
        run_op(12'h800, 5'd4,  32'h0000_3000, 1'b0);  // R4 highest bit
        run_op(12'hA5A, 5'd12, 32'h0000_4000, 1'b1);  // R9 start held
        run_op(12'h000, 5'd1,  32'h0000_0100, 1'b1);  // R8 + R9
        run_op(12'h00E, 5'd5,  32'h0000_0008, 1'b0);  // R3 wrap below zero
        for (int k = 0; k < 20; k++) begin
            logic [11:0] rm;
            logic [4:0]  ri;
            rm = 12'($urandom);
            ri = 5'($urandom);
            run_op(rm, ri, {$urandom} & 32'hFFFF_FFFC, k[0]);
        end
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule